// File: doc/BRIEF.md
# AC97 Codec Register Access Controller

This block is the host end of an AC97 link that carries codec register traffic: register reads, register writes, and the cold and warm link resets. Software drives it through a small word-addressed register file. To write a codec register, software first loads the value into the command data register and then writes the command address register with the read/write select clear. To read a codec register, software writes only the command address register, with the select set, and then waits for the codec's answer.

The serial link is abstracted at frame level. Each time the link layer pulses `tx_frame_i`, it takes whatever the block presents on the command address and command data slot outputs in that cycle. Sticky transmit flags then tell software which slots went out. Each received frame arrives as a pulse on `rx_frame_i` with the codec-ready tag and the optional status address and status data slots. The block captures these slots and raises sticky receive flags that software clears.

The control register holds the cold-reset, warm-reset and link-start bits, and it reports codec-ready. The audio control register gates command transmission with its 12-bit-alignment bit and stores the per-direction sample depth selects. PCM slots and DMA are handled elsewhere.

Top module: `ac97_cmd_ctrl`

## Requirements
- R1: After reset every register reads zero, `link_rst_no` is high, `sync_o` is low and `frame_en_o` is low.
- R2: Word offsets are: control 0, audio control 1, command address 2, command data 3, transmit status 4, receive status 5, status address 6, status data 7. In the command address register, bits 18:12 hold the codec register index and bit 19 set means read. The command data register holds a 16-bit value in bits 19:4. On the first frame after a command address write, `tx_slot1_o` carries {select, index, 12'b0} with `tx_slot1_vld_o` high. For a write, `tx_slot2_o` carries {value, 4'b0} with `tx_slot2_vld_o` high. For a read, `tx_slot2_vld_o` stays low.
- R3: A pending command is sent in exactly one frame. Later frames carry no valid command slot until the command address register is written again.
- R4: A second command address write made before the pending command is sent replaces that command.
- R5: Transmit status bit 31 is set when a command address slot is sent, and bit 30 when a command data slot is sent. Each bit stays set until software writes that bit as zero. A hardware set in the same cycle as a software clear leaves the bit set.
- R6: A received status address slot sets receive status bit 22 and places the returned index in bits 18:12 of the status address register. A received status data slot sets receive status bit 21 and places bits 19:4 of the slot in bits 19:4 of the status data register. Writing a bit as zero clears it.
- R7: In the control register, bit 5 starts the link, bit 11 holds a cold reset and bit 10 holds a warm reset. While bit 11 is set, `link_rst_no` is low and codec-ready reads zero. While bit 10 is set, `sync_o` is high. `frame_en_o` is high only when bit 5 is set and both reset bits are clear, and no command slot is valid while it is low.
- R8: Control bit 15 is read-only. It reports the codec-ready tag of the most recent received frame, and writes to it are ignored.
- R9: Command slots are withheld while audio control bit 26 is clear, and the command remains pending. Audio control bits 30, 29, 26 and 24:21 are writable and read back. All other audio control bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 3 | Register word offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| tx_frame_i | input | 1 | Link takes the outgoing command slots this cycle |
| tx_slot1_vld_o | output | 1 | Command address slot valid |
| tx_slot1_o | output | 20 | Command address slot content |
| tx_slot2_vld_o | output | 1 | Command data slot valid |
| tx_slot2_o | output | 20 | Command data slot content |
| frame_en_o | output | 1 | Link may issue frames |
| link_rst_no | output | 1 | Codec cold reset, active low |
| sync_o | output | 1 | Sync forced high for warm reset |
| rx_frame_i | input | 1 | A received frame is presented |
| rx_codec_rdy_i | input | 1 | Codec-ready tag bit of the received frame |
| rx_slot1_vld_i | input | 1 | Status address slot present |
| rx_slot1_i | input | 20 | Status address slot content |
| rx_slot2_vld_i | input | 1 | Status data slot present |
| rx_slot2_i | input | 20 | Status data slot content |

## Verification
The hardest case to reach from the ports is a software clear of a transmit flag that lands in the same cycle as the frame that sets the flag. The bench reaches it by driving the status-register write and the `tx_frame_i` pulse on the same clock edge. A second difficult case is a command held back by a reset or a clear alignment bit. The bench leaves such a command pending through several frames and confirms it goes out exactly once after the gate opens.

// File: rtl/ac97_cmd_pkg.sv
package ac97_cmd_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned VAL_W  = 16;
  localparam int unsigned SLOT_W = 20;

  localparam logic [REG_AW-1:0] OFF_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] OFF_ACTL  = 3'd1;
  localparam logic [REG_AW-1:0] OFF_CADDR = 3'd2;
  localparam logic [REG_AW-1:0] OFF_CDATA = 3'd3;
  localparam logic [REG_AW-1:0] OFF_TXST  = 3'd4;
  localparam logic [REG_AW-1:0] OFF_RXST  = 3'd5;
  localparam logic [REG_AW-1:0] OFF_SADDR = 3'd6;
  localparam logic [REG_AW-1:0] OFF_SDATA = 3'd7;

  localparam int unsigned B_RDY   = 15;
  localparam int unsigned B_COLD  = 11;
  localparam int unsigned B_WARM  = 10;
  localparam int unsigned B_START = 5;
  localparam int unsigned B_RDSEL = 19;
  localparam int unsigned IDX_LSB = 12;
  localparam int unsigned VAL_LSB = 4;
  localparam int unsigned B_TXA   = 31;
  localparam int unsigned B_TXD   = 30;
  localparam int unsigned B_RXA   = 22;
  localparam int unsigned B_RXD   = 21;
  localparam int unsigned B_ALIGN = 26;
  localparam logic [31:0] ACTL_MASK = 32'h65E0_0000;

  localparam int unsigned N_FLAGS = 4;
  localparam int unsigned F_TXA = 0;
  localparam int unsigned F_TXD = 1;
  localparam int unsigned F_RXA = 2;
  localparam int unsigned F_RXD = 3;
endpackage

// File: rtl/ac97_sticky_flag.sv
module ac97_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= 1'b0;
    else         q_q <= set_i | (q_q & ~clr_i);
  end

  assign q_o = q_q;

  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r5_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/ac97_cmd_tx.sv
module ac97_cmd_tx
  import ac97_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_addr_i,
  input  logic              wr_data_i,
  input  logic [31:0]       wdata_i,
  input  logic              gate_i,
  input  logic              tx_frame_i,
  output logic              slot1_vld_o,
  output logic [SLOT_W-1:0] slot1_o,
  output logic              slot2_vld_o,
  output logic [SLOT_W-1:0] slot2_o,
  output logic              sent_addr_o,
  output logic              sent_data_o,
  output logic [31:0]       caddr_o,
  output logic [31:0]       cdata_o
);
  logic             pend_q, rd_q;
  logic [IDX_W-1:0] idx_q;
  logic [VAL_W-1:0] val_q;
  logic             send;

  assign slot1_vld_o = pend_q & gate_i;
  assign slot2_vld_o = pend_q & gate_i & ~rd_q;
  assign send        = tx_frame_i & slot1_vld_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
    end else if (wr_addr_i) begin
      pend_q <= 1'b1;
      rd_q   <= wdata_i[B_RDSEL];
      idx_q  <= wdata_i[IDX_LSB +: IDX_W];
    end else if (send) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        val_q <= '0;
    else if (wr_data_i) val_q <= wdata_i[VAL_LSB +: VAL_W];
  end

  assign slot1_o     = {rd_q, idx_q, {IDX_LSB{1'b0}}};
  assign slot2_o     = {val_q, {VAL_LSB{1'b0}}};
  assign sent_addr_o = send;
  assign sent_data_o = tx_frame_i & slot2_vld_o;

  always_comb begin
    caddr_o = '0;
    caddr_o[B_RDSEL] = rd_q;
    caddr_o[IDX_LSB +: IDX_W] = idx_q;
    cdata_o = '0;
    cdata_o[VAL_LSB +: VAL_W] = val_q;
  end

  a_r3_sent_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send && !wr_addr_i) |=> !slot1_vld_o);
  a_r4_replace: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_addr_i |=> (pend_q && (idx_q == $past(wdata_i[IDX_LSB +: IDX_W]))));
  a_r7_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |-> !(slot1_vld_o || slot2_vld_o));
endmodule

// File: rtl/ac97_cmd_rx.sv
module ac97_cmd_rx
  import ac97_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cold_i,
  input  logic              rx_frame_i,
  input  logic              rdy_i,
  input  logic              s1_vld_i,
  input  logic [SLOT_W-1:0] s1_i,
  input  logic              s2_vld_i,
  input  logic [SLOT_W-1:0] s2_i,
  output logic              got_addr_o,
  output logic              got_data_o,
  output logic              rdy_o,
  output logic [31:0]       saddr_o,
  output logic [31:0]       sdata_o
);
  logic             rdy_q;
  logic [IDX_W-1:0] idx_q;
  logic [VAL_W-1:0] val_q;
  logic             live;

  assign live       = rx_frame_i & ~cold_i;
  assign got_addr_o = live & s1_vld_i;
  assign got_data_o = live & s2_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0;
      idx_q <= '0;
      val_q <= '0;
    end else begin
      if (cold_i)    rdy_q <= 1'b0;
      else if (live) rdy_q <= rdy_i;
      if (got_addr_o) idx_q <= s1_i[IDX_LSB +: IDX_W];
      if (got_data_o) val_q <= s2_i[VAL_LSB +: VAL_W];
    end
  end

  assign rdy_o = rdy_q;
  always_comb begin
    saddr_o = '0;
    saddr_o[IDX_LSB +: IDX_W] = idx_q;
    sdata_o = '0;
    sdata_o[VAL_LSB +: VAL_W] = val_q;
  end

  a_r7_rdy_low_cold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_i |=> !rdy_o);
  a_r8_rdy_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live && !cold_i) |=> (rdy_o == $past(rdy_i)));
endmodule

// File: rtl/ac97_cmd_ctrl.sv
module ac97_cmd_ctrl
  import ac97_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [REG_AW-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              tx_frame_i,
  output logic              tx_slot1_vld_o,
  output logic [SLOT_W-1:0] tx_slot1_o,
  output logic              tx_slot2_vld_o,
  output logic [SLOT_W-1:0] tx_slot2_o,
  output logic              frame_en_o,
  output logic              link_rst_no,
  output logic              sync_o,
  input  logic              rx_frame_i,
  input  logic              rx_codec_rdy_i,
  input  logic              rx_slot1_vld_i,
  input  logic [SLOT_W-1:0] rx_slot1_i,
  input  logic              rx_slot2_vld_i,
  input  logic [SLOT_W-1:0] rx_slot2_i
);
  logic        wr;
  logic        cold_q, warm_q, start_q;
  logic [31:0] actl_q;
  logic        gate, rdy;
  logic [31:0] caddr, cdata, saddr, sdata;
  logic [N_FLAGS-1:0] f_set, f_clr, f_q;

  assign wr = bus_req_i & bus_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cold_q  <= 1'b0;
      warm_q  <= 1'b0;
      start_q <= 1'b0;
      actl_q  <= '0;
    end else if (wr) begin
      if (bus_addr_i == OFF_CTRL) begin
        cold_q  <= bus_wdata_i[B_COLD];
        warm_q  <= bus_wdata_i[B_WARM];
        start_q <= bus_wdata_i[B_START];
      end
      if (bus_addr_i == OFF_ACTL) actl_q <= bus_wdata_i & ACTL_MASK;
    end
  end

  assign frame_en_o  = start_q & ~cold_q & ~warm_q;
  assign link_rst_no = ~cold_q;
  assign sync_o      = warm_q;
  assign gate        = frame_en_o & actl_q[B_ALIGN];

  ac97_cmd_tx u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_addr_i   (wr && bus_addr_i == OFF_CADDR),
    .wr_data_i   (wr && bus_addr_i == OFF_CDATA),
    .wdata_i     (bus_wdata_i),
    .gate_i      (gate),
    .tx_frame_i  (tx_frame_i),
    .slot1_vld_o (tx_slot1_vld_o),
    .slot1_o     (tx_slot1_o),
    .slot2_vld_o (tx_slot2_vld_o),
    .slot2_o     (tx_slot2_o),
    .sent_addr_o (f_set[F_TXA]),
    .sent_data_o (f_set[F_TXD]),
    .caddr_o     (caddr),
    .cdata_o     (cdata)
  );

  ac97_cmd_rx u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cold_i     (cold_q),
    .rx_frame_i (rx_frame_i),
    .rdy_i      (rx_codec_rdy_i),
    .s1_vld_i   (rx_slot1_vld_i),
    .s1_i       (rx_slot1_i),
    .s2_vld_i   (rx_slot2_vld_i),
    .s2_i       (rx_slot2_i),
    .got_addr_o (f_set[F_RXA]),
    .got_data_o (f_set[F_RXD]),
    .rdy_o      (rdy),
    .saddr_o    (saddr),
    .sdata_o    (sdata)
  );

  localparam int unsigned FLAG_BIT [N_FLAGS] = '{B_TXA, B_TXD, B_RXA, B_RXD};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    localparam logic [REG_AW-1:0] FOFF = (g < 2) ? OFF_TXST : OFF_RXST;
    assign f_clr[g] = wr && bus_addr_i == FOFF && !bus_wdata_i[FLAG_BIT[g]];
    ac97_sticky_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (f_set[g]),
      .clr_i  (f_clr[g]),
      .q_o    (f_q[g])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i)
      OFF_CTRL: begin
        bus_rdata_o[B_RDY]   = rdy;
        bus_rdata_o[B_COLD]  = cold_q;
        bus_rdata_o[B_WARM]  = warm_q;
        bus_rdata_o[B_START] = start_q;
      end
      OFF_ACTL:  bus_rdata_o = actl_q;
      OFF_CADDR: bus_rdata_o = caddr;
      OFF_CDATA: bus_rdata_o = cdata;
      OFF_TXST: begin
        bus_rdata_o[B_TXA] = f_q[F_TXA];
        bus_rdata_o[B_TXD] = f_q[F_TXD];
      end
      OFF_RXST: begin
        bus_rdata_o[B_RXA] = f_q[F_RXA];
        bus_rdata_o[B_RXD] = f_q[F_RXD];
      end
      OFF_SADDR: bus_rdata_o = saddr;
      OFF_SDATA: bus_rdata_o = sdata;
      default:   bus_rdata_o = '0;
    endcase
  end

  a_r7_no_cmd_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cold_q || warm_q) |-> !tx_slot1_vld_o);
  a_r9_align_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !actl_q[B_ALIGN] |-> !tx_slot1_vld_o);
endmodule

// File: tb/ac97_cmd_ctrl_tb_top.sv
module ac97_cmd_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [2:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        tx_frame = 0;
  logic        s1v, s2v, fen, lrst_n, sync;
  logic [19:0] s1, s2;
  logic        rx_frame = 0, rx_rdy = 0, rx1v = 0, rx2v = 0;
  logic [19:0] rx1 = 0, rx2 = 0;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ac97_cmd_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .tx_frame_i(tx_frame),
    .tx_slot1_vld_o(s1v), .tx_slot1_o(s1),
    .tx_slot2_vld_o(s2v), .tx_slot2_o(s2),
    .frame_en_o(fen), .link_rst_no(lrst_n), .sync_o(sync),
    .rx_frame_i(rx_frame), .rx_codec_rdy_i(rx_rdy),
    .rx_slot1_vld_i(rx1v), .rx_slot1_i(rx1),
    .rx_slot2_vld_i(rx2v), .rx_slot2_i(rx2)
  );

  typedef struct packed {
    logic        rd;
    logic [6:0]  idx;
    logic [15:0] val;
  } cmd_t;

  localparam cmd_t VEC [5] = '{
    '{1'b0, 7'h02, 16'h8080},
    '{1'b1, 7'h7C, 16'h0000},
    '{1'b0, 7'h7F, 16'hFFFF},
    '{1'b1, 7'h00, 16'h1234},
    '{1'b0, 7'h18, 16'hA5C3}
  };

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic frame(output logic v1, output logic [19:0] o1, output logic v2, output logic [19:0] o2);
    tx_frame = 1; #1;
    v1 = s1v; o1 = s1; v2 = s2v; o2 = s2;
    @(negedge clk);
    tx_frame = 0;
  endtask

  task automatic rx(input logic rdy, input logic v1, input logic [19:0] a, input logic v2, input logic [19:0] d);
    rx_frame = 1; rx_rdy = rdy; rx1v = v1; rx1 = a; rx2v = v2; rx2 = d;
    @(negedge clk);
    rx_frame = 0; rx1v = 0; rx2v = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic v1, v2;
    logic [19:0] o1, o2;

    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      bus_rd(a[2:0], r); chk("R1 reg zero", r, 0);
    end
    chk("R1 link_rst_no", {31'b0, lrst_n}, 1);
    chk("R1 sync", {31'b0, sync}, 0);
    chk("R1 frame_en", {31'b0, fen}, 0);

    // R9 ACTL readback mask
    bus_wr(3'd1, 32'hFFFF_FFFF);
    bus_rd(3'd1, r); chk("R9 actl mask", r, 32'h65E0_0000);
    bus_wr(3'd1, 32'h0);
    bus_wr(3'd0, 32'h20);
    chk("R7 frame_en with start", {31'b0, fen}, 1);

    // R9 command withheld while alignment bit clear
    bus_wr(3'd3, 32'h0001_2340);
    bus_wr(3'd2, 32'h0000_5000);
    frame(v1, o1, v2, o2); chk("R9 withheld", {31'b0, v1}, 0);
    bus_wr(3'd1, 32'h0400_0000);
    frame(v1, o1, v2, o2);
    chk("R9 sent after align", {v1, v2, 10'b0, o1}, {1'b1, 1'b1, 10'b0, 20'h05000});
    chk("R9 data slot", {12'b0, o2}, 32'h0001_2340);
    bus_wr(3'd4, 32'h0);

    // R2/R3/R5 vector table
    foreach (VEC[i]) begin
      bus_wr(3'd3, {12'b0, VEC[i].val, 4'b0});
      bus_wr(3'd2, {12'b0, VEC[i].rd, VEC[i].idx, 12'b0});
      bus_rd(3'd2, r); chk("R2 caddr readback", r, {12'b0, VEC[i].rd, VEC[i].idx, 12'b0});
      frame(v1, o1, v2, o2);
      chk("R2 slot1", {11'b0, v1, o1}, {11'b0, 1'b1, VEC[i].rd, VEC[i].idx, 12'b0});
      chk("R2 slot2 valid", {31'b0, v2}, {31'b0, ~VEC[i].rd});
      if (!VEC[i].rd) chk("R2 slot2", {12'b0, o2}, {12'b0, VEC[i].val, 4'b0});
      bus_rd(3'd4, r); chk("R5 tx flags", r, {1'b1, ~VEC[i].rd, 30'b0});
      frame(v1, o1, v2, o2); chk("R3 once", {30'b0, v1, v2}, 0);
      bus_rd(3'd4, r); chk("R5 sticky", r, {1'b1, ~VEC[i].rd, 30'b0});
      bus_wr(3'd4, 32'h8000_0000);
      bus_rd(3'd4, r); chk("R5 clear bit30 only", r, 32'h8000_0000);
      bus_wr(3'd4, 32'h0);
      bus_rd(3'd4, r); chk("R5 cleared", r, 0);
    end

    // R4 replacement
    bus_wr(3'd3, 32'h0000_BEE0);
    bus_wr(3'd2, 32'h0009_1000);
    bus_wr(3'd2, 32'h0002_2000);
    frame(v1, o1, v2, o2);
    chk("R4 replaced slot1", {11'b0, v1, o1}, {11'b0, 1'b1, 20'h22000});
    chk("R4 replaced is write", {31'b0, v2}, 1);
    frame(v1, o1, v2, o2); chk("R4 only once", {31'b0, v1}, 0);

    // R5 hardware set wins over simultaneous clear
    bus_wr(3'd4, 32'h0);
    bus_wr(3'd2, 32'h0008_3000);
    req = 1; we = 1; addr = 3'd4; wdata = 32'h0; tx_frame = 1;
    @(negedge clk);
    req = 0; we = 0; tx_frame = 0;
    bus_rd(3'd4, r); chk("R5 set wins", r, 32'h8000_0000);
    bus_wr(3'd4, 32'h0);

    // R6 receive capture
    rx(1'b0, 1'b1, 20'h26000, 1'b0, 20'h0);
    bus_rd(3'd5, r); chk("R6 addr flag", r, 32'h0040_0000);
    bus_rd(3'd6, r); chk("R6 saddr", r, 32'h0002_6000);
    rx(1'b0, 1'b0, 20'h0, 1'b1, 20'hBEEF5);
    bus_rd(3'd5, r); chk("R6 both flags", r, 32'h0060_0000);
    bus_rd(3'd7, r); chk("R6 sdata", r, 32'h000B_EEF0);
    bus_wr(3'd5, 32'h0020_0000);
    bus_rd(3'd5, r); chk("R6 clear bit22", r, 32'h0020_0000);
    bus_wr(3'd5, 32'h0);
    bus_rd(3'd5, r); chk("R6 cleared", r, 0);

    // R8 codec-ready follows tag
    rx(1'b1, 1'b0, 20'h0, 1'b0, 20'h0);
    bus_rd(3'd0, r); chk("R8 ready set", r, 32'h0000_8020);
    rx(1'b0, 1'b0, 20'h0, 1'b0, 20'h0);
    bus_rd(3'd0, r); chk("R8 ready clear", r, 32'h0000_0020);
    bus_wr(3'd0, 32'h0000_8020);
    bus_rd(3'd0, r); chk("R8 read-only", r, 32'h0000_0020);
    rx(1'b1, 1'b0, 20'h0, 1'b0, 20'h0);

    // R7 cold reset
    bus_wr(3'd2, 32'h0000_4000);
    bus_wr(3'd0, 32'h0000_0820);
    chk("R7 cold link_rst_no", {30'b0, lrst_n, fen}, 0);
    rx(1'b1, 1'b0, 20'h0, 1'b0, 20'h0);
    bus_rd(3'd0, r); chk("R7 cold ready zero", r, 32'h0000_0820);
    frame(v1, o1, v2, o2); chk("R7 cold no cmd", {31'b0, v1}, 0);

    // R7 warm reset
    bus_wr(3'd0, 32'h0000_0420);
    chk("R7 warm sync", {29'b0, lrst_n, sync, fen}, 32'd6);
    frame(v1, o1, v2, o2); chk("R7 warm no cmd", {31'b0, v1}, 0);
    bus_wr(3'd0, 32'h0000_0020);
    chk("R7 warm released", {30'b0, sync, fen}, 1);
    frame(v1, o1, v2, o2);
    chk("R7 pending sent after reset", {11'b0, v1, o1}, {11'b0, 1'b1, 20'h04000});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule